// File: doc/BRIEF.md
# Synchronous Buck PWM Gate Sequencer

This block drives the two gate-enable lines of a fixed-frequency synchronous step-down converter. A free-running counter acts as a digital sawtooth. Each switching period begins at the counter's valley, where a one-shot latch turns the high-side request on. The latch turns off once the counter reaches the duty-command word, or when the counter enters the ramp-fall window at the end of the period, whichever comes first. The low-side switch takes the rest of the period. A non-overlap interval separates the two gates in both directions.

Two flags from outside window comparators can override the duty word. A too-low output forces the widest allowed pulse, and a too-high output forces no pulse at all. The gates stay low until the enable and both supply-good flags are present. A shutdown input from the supervisor masks both gates at once, in the same cycle. Period, ramp-fall length and dead time are derived from the clock frequency, the switching frequency, the duty ceiling in percent and the dead time in nanoseconds.

The counts used below are these:

- P is the period in clocks: clock frequency divided by switching frequency.
- B is the ramp-fall length: P·(100−max duty %)/100, rounded up, and at least 1.
- A is the active ramp: P−B.
- D is the dead time: dead-time ns · clock MHz / 1000, rounded up, and at least 1.
- W is the request width in a period. With no override, W = min(duty, A).

The configuration must keep B > D.

Top module: `buck_gate_seq`

## Requirements
- R1: The high-side request rises only at the counter valley, so the high-side gate has at most one rising edge per P-cycle period, even when the duty word changes within the period.
- R2: In steady state with constant inputs, the high-side gate is high for W−D cycles per period when W > D, and for 0 cycles otherwise.
- R3: In steady state, the low-side gate is high for P cycles per period when W = 0, for P−D cycles when 0 < W ≤ D, and for P−W−D cycles when W > D.
- R4: The two gates are never high in the same cycle.
- R5: Before either gate rises, both gates have been low for at least D consecutive cycles.
- R6: While the too-low flag is 1 and the too-high flag is 0, W = A whatever the duty word.
- R7: While the too-high flag is 1, W = 0, even when the too-low flag is also 1.
- R8: When the enable, the logic-supply-good flag or the driver-supply-good flag is 0 at a clock edge, both gates are low in the following cycle and stay low while it remains 0.
- R9: When shutdown is 1, both gates are low in that same cycle without waiting for a clock edge. After release, normal counts resume.
- R10: When the synchronous reset is 1 at a clock edge, both gates are low from the following cycle. The reset clears the pulse latch and the counter.
- R11: The high-side request is off for the last B counts of each period, so duty words of A or more give the same on-time as A.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Converter enable |
| logic_ok | input | 1 | Logic supply above its lockout threshold |
| drive_ok | input | 1 | Driver supply above its lockout threshold |
| shutdown | input | 1 | Supervisor kill; masks both gates immediately |
| win_lo | input | 1 | Output below the lower window bound |
| win_hi | input | 1 | Output above the upper window bound |
| duty | input | DW | Duty command in clock counts, 0..P |
| hs_gate | output | 1 | High-side (switch) gate enable |
| ls_gate | output | 1 | Low-side (rectifier) gate enable |

## Verification
The following are checked as cycle-level properties on every cycle:

- the gates never overlap;
- the both-low gap before any rise is at least D;
- the shutdown mask;
- the one-cycle clear after reset or a missing supply or enable;
- the rule that the latch rises only just after the valley and stays off through the ramp fall.

The exact per-period on-times of each gate depend on how the latch, the dead-time counter and the ramp interact over a whole period. Only the bench's scenarios show them. It sweeps every duty word with and without the window overrides and compares the per-period high counts of each gate with the arithmetic for W. It also shows that a duty word changing every cycle never yields a second high-side pulse within a period.

// File: rtl/buck_gate_seq.sv
`timescale 1ns/1ps
module buck_gate_seq #(
  parameter  int CLK_HZ       = 125_000_000,
  parameter  int SW_HZ        = 300_000,
  parameter  int MAX_DUTY_PCT = 95,
  parameter  int DEAD_NS      = 100,
  localparam int PERIOD_CYC   = CLK_HZ / SW_HZ,
  localparam int DW           = $clog2(PERIOD_CYC + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic          logic_ok,
  input  logic          drive_ok,
  input  logic          shutdown,
  input  logic          win_lo,
  input  logic          win_hi,
  input  logic [DW-1:0] duty,
  output logic          hs_gate,
  output logic          ls_gate
);

  localparam int BLANK_RAW = (PERIOD_CYC * (100 - MAX_DUTY_PCT) + 99) / 100;
  localparam int BLANK_CYC = (BLANK_RAW < 1) ? 1 : BLANK_RAW;
  localparam int RISE_CYC  = PERIOD_CYC - BLANK_CYC;
  localparam int DEAD_RAW  = (DEAD_NS * (CLK_HZ / 1_000_000) + 999) / 1000;
  localparam int DEAD_CYC  = (DEAD_RAW < 1) ? 1 : DEAD_RAW;
  localparam int QW        = $clog2(DEAD_CYC + 1);

  localparam logic [DW-1:0] LAST_V = DW'(PERIOD_CYC - 1);
  localparam logic [DW-1:0] RISE_V = DW'(RISE_CYC);
  localparam logic [DW-1:0] FULL_V = DW'(PERIOD_CYC);
  localparam logic [QW-1:0] QMAX_V = QW'(DEAD_CYC);
  localparam logic [QW-1:0] QGO_V  = QW'(DEAD_CYC - 1);

  logic [DW-1:0] ramp;
  logic [DW-1:0] duty_eff;
  logic [QW-1:0] quiet;
  logic          pulse;
  logic          hs_q;
  logic          ls_q;

  wire run      = en & logic_ok & drive_ok & ~shutdown;
  wire valley   = (ramp == '0);
  wire blanking = (ramp >= RISE_V);

  always_comb begin
    if (win_hi)      duty_eff = '0;
    else if (win_lo) duty_eff = FULL_V;
    else             duty_eff = duty;
  end

  wire trip     = blanking | (ramp >= duty_eff);
  wire pulse_d  = run & ~trip & (valley | pulse);
  wire gap_done = ~hs_q & ~ls_q & (quiet >= QGO_V);
  wire hs_d     = run &  pulse & (hs_q | gap_done);
  wire ls_d     = run & ~pulse & (ls_q | gap_done);

  always_ff @(posedge clk) begin
    if (rst) ramp <= '0;
    else     ramp <= (ramp == LAST_V) ? '0 : ramp + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pulse <= 1'b0;
      hs_q  <= 1'b0;
      ls_q  <= 1'b0;
    end else begin
      pulse <= pulse_d;
      hs_q  <= hs_d;
      ls_q  <= ls_d;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || hs_q || ls_q) quiet <= '0;
    else if (quiet != QMAX_V) quiet <= quiet + 1'b1;
  end

  assign hs_gate = hs_q & ~shutdown;
  assign ls_gate = ls_q & ~shutdown;

endmodule

// File: rtl/buck_gate_seq_chk.sv
`timescale 1ns/1ps
module buck_gate_seq_chk #(
  parameter int DW   = 9,
  parameter int RISE = 395,
  parameter int DEAD = 13
) (
  input logic          clk,
  input logic          rst,
  input logic          en,
  input logic          logic_ok,
  input logic          drive_ok,
  input logic          shutdown,
  input logic          hs_gate,
  input logic          ls_gate,
  input logic [DW-1:0] ramp,
  input logic          pulse
);

  logic [7:0] lowrun;

  always_ff @(posedge clk) begin
    if (rst || hs_gate || ls_gate) lowrun <= '0;
    else if (lowrun != 8'hFF)      lowrun <= lowrun + 1'b1;
  end

  p_one_pulse_r1: assert property (@(posedge clk) disable iff (rst)
    $rose(pulse) |-> (ramp == DW'(1)));

  p_no_overlap_r4: assert property (@(posedge clk) disable iff (rst)
    !(hs_gate && ls_gate));

  p_dead_gap_r5: assert property (@(posedge clk) disable iff (rst)
    ((hs_gate || ls_gate) && $past(!hs_gate && !ls_gate)) |-> (int'(lowrun) >= DEAD));

  p_supply_off_r8: assert property (@(posedge clk) disable iff (rst)
    (!en || !logic_ok || !drive_ok) |=> (!hs_gate && !ls_gate));

  p_kill_now_r9: assert property (@(posedge clk) disable iff (rst)
    shutdown |-> (!hs_gate && !ls_gate));

  p_reset_off_r10: assert property (@(posedge clk)
    rst |=> (!hs_gate && !ls_gate));

  p_blank_off_r11: assert property (@(posedge clk) disable iff (rst)
    ((int'(ramp) > RISE) || (ramp == '0)) |-> !pulse);

endmodule

bind buck_gate_seq buck_gate_seq_chk #(
  .DW(DW), .RISE(RISE_CYC), .DEAD(DEAD_CYC)
) u_chk (
  .clk(clk), .rst(rst), .en(en), .logic_ok(logic_ok), .drive_ok(drive_ok),
  .shutdown(shutdown), .hs_gate(hs_gate), .ls_gate(ls_gate),
  .ramp(ramp), .pulse(pulse)
);

// File: tb/sim_buck_gate_seq.sv
`timescale 1ns/1ps
module sim_buck_gate_seq;
  localparam int CLK_HZ = 125_000_000;
  localparam int SW_HZ  = 3_125_000;
  localparam int MAXD   = 80;
  localparam int DNS    = 24;
  localparam int P      = CLK_HZ / SW_HZ;
  localparam int BL     = ((P * (100 - MAXD) + 99) / 100 < 1) ? 1 : (P * (100 - MAXD) + 99) / 100;
  localparam int A      = P - BL;
  localparam int DT     = ((DNS * (CLK_HZ / 1_000_000) + 999) / 1000 < 1) ? 1 : (DNS * (CLK_HZ / 1_000_000) + 999) / 1000;
  localparam int DW     = $clog2(P + 1);

  logic clk = 1'b0;
  logic rst = 1'b1, en = 1'b1, logic_ok = 1'b1, drive_ok = 1'b1, shutdown = 1'b0;
  logic win_lo = 1'b0, win_hi = 1'b0;
  logic [DW-1:0] duty = '0;
  logic hs_gate, ls_gate;

  int compared = 0, mismatched = 0;
  bit mon_on = 0, pulse_mon = 0, done = 0;
  int cyc = 0, lowrun = 0, last_rise = -1, rises = 0;
  logic prev_hs = 1'b0, prev_any = 1'b0;

  always #4 clk = ~clk;

  buck_gate_seq #(.CLK_HZ(CLK_HZ), .SW_HZ(SW_HZ), .MAX_DUTY_PCT(MAXD), .DEAD_NS(DNS)) u0 (
    .clk(clk), .rst(rst), .en(en), .logic_ok(logic_ok), .drive_ok(drive_ok),
    .shutdown(shutdown), .win_lo(win_lo), .win_hi(win_hi), .duty(duty),
    .hs_gate(hs_gate), .ls_gate(ls_gate));

  task automatic check(string req, int act, int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_hs(int w);
    return (w > DT) ? w - DT : 0;
  endfunction

  function automatic int exp_ls(int w);
    if (w == 0) return P;
    if (w <= DT) return P - DT;
    return P - w - DT;
  endfunction

  task automatic measure(output int nh, output int nl);
    repeat (2 * P) @(negedge clk);
    nh = 0; nl = 0;
    for (int i = 0; i < P; i++) begin
      @(negedge clk);
      nh += int'(hs_gate);
      nl += int'(ls_gate);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    if (mon_on) begin
      if (hs_gate || ls_gate) begin
        if (!prev_any) check("R5 dead gap", (lowrun >= DT) ? 1 : 0, 1);
        lowrun = 0;
      end else lowrun++;
      if (hs_gate && ls_gate) check("R4 overlap", 1, 0);
      if (pulse_mon && hs_gate && !prev_hs) begin
        if (last_rise >= 0) check("R1 rise spacing", (cyc - last_rise >= P) ? 1 : 0, 1);
        last_rise = cyc;
        rises++;
      end
    end
    prev_any = hs_gate | ls_gate;
    prev_hs  = hs_gate;
  end

  initial begin
    int nh, nl, w;
    repeat (5) @(negedge clk);
    check("R10 reset hs", int'(hs_gate), 0);
    check("R10 reset ls", int'(ls_gate), 0);
    rst = 1'b0;
    mon_on = 1;

    for (int d = 0; d <= P + 5; d++) begin
      duty = DW'(d);
      w = (d < A) ? d : A;
      measure(nh, nl);
      if (d >= A) check($sformatf("R11 hs d=%0d", d), nh, exp_hs(A));
      else        check($sformatf("R2 hs d=%0d", d), nh, exp_hs(w));
      check($sformatf("R3 ls d=%0d", d), nl, exp_ls(w));
    end

    duty = DW'(4);
    win_lo = 1'b1;
    measure(nh, nl);
    check("R6 hs low-flag", nh, exp_hs(A));
    check("R6 ls low-flag", nl, exp_ls(A));
    win_lo = 1'b0; duty = DW'(20); win_hi = 1'b1;
    measure(nh, nl);
    check("R7 hs high-flag", nh, 0);
    check("R7 ls high-flag", nl, P);
    win_lo = 1'b1;
    measure(nh, nl);
    check("R7 hs both flags", nh, 0);
    check("R7 ls both flags", nl, P);
    win_lo = 1'b0; win_hi = 1'b0;
    measure(nh, nl);
    check("R2 hs restored", nh, exp_hs(20));

    for (int k = 0; k < 3; k++) begin
      if (k == 0) en = 1'b0; else if (k == 1) logic_ok = 1'b0; else drive_ok = 1'b0;
      @(negedge clk);
      check($sformatf("R8 next-cycle off %0d", k), int'(hs_gate | ls_gate), 0);
      measure(nh, nl);
      check($sformatf("R8 held off %0d", k), nh + nl, 0);
      en = 1'b1; logic_ok = 1'b1; drive_ok = 1'b1;
      measure(nh, nl);
      check($sformatf("R8 resume hs %0d", k), nh, exp_hs(20));
    end

    while (!hs_gate) @(negedge clk);
    shutdown = 1'b1;
    #1;
    check("R9 same-cycle hs", int'(hs_gate), 0);
    check("R9 same-cycle ls", int'(ls_gate), 0);
    repeat (3) @(negedge clk);
    shutdown = 1'b0;
    measure(nh, nl);
    check("R9 resume hs", nh, exp_hs(20));
    check("R9 resume ls", nl, exp_ls(20));

    while (!hs_gate) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check("R10 mid-run hs", int'(hs_gate), 0);
    check("R10 mid-run ls", int'(ls_gate), 0);
    repeat (4) @(negedge clk);
    rst = 1'b0;
    measure(nh, nl);
    check("R10 resume hs", nh, exp_hs(20));

    pulse_mon = 1;
    for (int i = 0; i < 30 * P; i++) begin
      duty = DW'($urandom_range(0, P + 5));
      @(negedge clk);
    end
    pulse_mon = 0;
    check("R1 rises seen", (rises > 5) ? 1 : 0, 1);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    #(150000 * 8);
    if (!done) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule